// File: doc/BRIEF.md
# NAND Sector Single-Bit ECC Engine

This engine builds a Hamming-style check code over one NAND sector while the sector's bytes stream through it. Each accepted byte folds its bits into two parity halves. One half holds the XOR of the position addresses of every set bit. The other half holds the XOR of the complements of those addresses. The position address of a bit is its byte index followed by its bit number.

The two halves are joined, with the address half on top, and presented inverted. As a result, an erased sector of all-ones bytes produces the all-ones code, which matches erased spare-area contents. When a stored code from the spare area is supplied, the engine XORs it with the computed code and classifies the result. The outcomes are: no error; a single data-bit error, reported with the byte to patch and a mask for the bad bit; a single flipped bit inside the stored code, where the data needs no change; or an error that cannot be corrected.

In use, a sector transfer begins with `start`. The bytes are then given with `dataValid`, the code is taken from `codeOut` for writing to the spare area, or a stored code is compared with `checkValid`. A read strobe on `codeRead` clears the engine, which then stays idle until the next `start`.

Top module: `nand_ecc1b`

## Requirements
- R1: After reset, `codeOut` is all ones, and both `done` and `statusValid` are 0.
- R2: A sector of 512 bytes of 0xFF yields `codeOut` = 0xFFFFFF.
- R3: `codeOut` equals the bitwise inverse of {A, B}. A is the 12-bit XOR, over every set data bit, of its address {byte index[8:0], bit number[2:0]}. B is the XOR of the complements of those addresses.
- R4: When the syndrome (`codeOut` XOR `storedCode`) is zero, `status` = 0 (clean), and `fixByte` and `fixMask` are 0.
- R5: When syndrome[23:12] XOR syndrome[11:0] equals 0xFFF, `status` = 1 (data fixed). In that case `fixByte` = syndrome[23:15] and `fixMask` has only bit syndrome[14:12] set.
- R6: When the syndrome has exactly one set bit, `status` = 2 (stored code hit) and `fixMask` = 0.
- R7: Any other non-zero syndrome gives `status` = 3 (uncorrectable) and `fixMask` = 0.
- R8: `done` rises in the cycle after the 512th byte is accepted. Further `dataValid` bytes leave `codeOut` unchanged.
- R9: A `codeRead` pulse returns `codeOut` to all ones and clears `done`. Bytes given before the next `start` have no effect on `codeOut`.
- R10: `statusValid` and the decode results appear one cycle after `checkValid`.
- R11: `start` clears the accumulated code, and accumulation then begins again at byte index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clear the code and arm accumulation at byte 0 |
| codeRead | input | 1 | Code-taken strobe: clears the code and disarms |
| dataValid | input | 1 | `dataByte` is valid this cycle |
| dataByte | input | 8 | Sector data byte |
| checkValid | input | 1 | Compare `storedCode` with the computed code |
| storedCode | input | 24 | Code read back from the spare area |
| codeOut | output | 24 | Packed, inverted computed code |
| done | output | 1 | All 512 bytes have been accepted |
| statusValid | output | 1 | Decode result valid |
| status | output | 2 | 0 clean, 1 data fixed, 2 stored-code hit, 3 uncorrectable |
| fixByte | output | 9 | Byte index to patch |
| fixMask | output | 8 | XOR mask for the patched byte |

## Verification
The hardest outcomes to reach through the ports are the single-bit syndromes at the edges of the address space: a bit flip at byte 0 bit 0, and a flip at byte 511 bit 7. Reaching them naturally would require corrupting exactly those bits in a 512-byte stream. Instead, the bench accumulates one known sector once, computes its reference code separately, and then issues a series of compares. In each compare, `storedCode` is the reference code XORed with a chosen syndrome, so one accumulation covers every decode class, including the edge positions and the stored-code hits at both ends of the word.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN   = 2'd0,
    ST_FIXED   = 2'd1,
    ST_CODEHIT = 2'd2,
    ST_BAD     = 2'd3
  } eccStatus_t;

  typedef struct packed {
    logic clearAcc;
    logic takeByte;
    logic latchCheck;
  } eccStrobe_t;
endpackage

// File: rtl/eccCtrl.sv
module eccCtrl
  import nand_ecc_pkg::*;
#(
  parameter int DATA_BYTES = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       codeRead,
  input  logic       dataValid,
  input  logic       checkValid,
  output eccStrobe_t strb,
  output logic       done
);
  localparam int CNT_W = $clog2(DATA_BYTES + 1);

  logic [CNT_W-1:0] byteCnt;
  logic             armed;
  logic             full;

  assign full = (byteCnt == CNT_W'(DATA_BYTES));

  always_comb begin
    strb.clearAcc   = start | codeRead;
    strb.takeByte   = armed & dataValid & ~full & ~start & ~codeRead;
    strb.latchCheck = checkValid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byteCnt <= '0;
      armed   <= 1'b0;
      done    <= 1'b0;
    end else if (start) begin
      byteCnt <= '0;
      armed   <= 1'b1;
      done    <= 1'b0;
    end else if (codeRead) begin
      byteCnt <= '0;
      armed   <= 1'b0;
      done    <= 1'b0;
    end else if (strb.takeByte) begin
      byteCnt <= byteCnt + 1'b1;
      if (byteCnt == CNT_W'(DATA_BYTES - 1)) done <= 1'b1;
    end
  end

  // R8: the count never passes the sector size
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    byteCnt <= CNT_W'(DATA_BYTES));

  // R8: done only rises right after a byte was accepted
  p_done_after_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(strb.takeByte));

  // R9: after a code read, no byte is accepted until a new start
  p_read_disarms_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (codeRead && !start) |=> (start || !strb.takeByte));
endmodule

// File: rtl/eccDatapath.sv
module eccDatapath
  import nand_ecc_pkg::*;
#(
  parameter int DATA_BYTES = 512,
  localparam int IDX_W  = $clog2(DATA_BYTES),
  localparam int HALF_W = IDX_W + 3,
  localparam int CODE_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  eccStrobe_t        strb,
  input  logic [7:0]        dataByte,
  input  logic [CODE_W-1:0] storedCode,
  output logic [CODE_W-1:0] codeOut,
  output logic              statusValid,
  output eccStatus_t        status,
  output logic [IDX_W-1:0]  fixByte,
  output logic [7:0]        fixMask
);
  logic [HALF_W-1:0] addrAcc, compAcc;
  logic [IDX_W-1:0]  posIdx;
  logic              bytePar;
  logic [2:0]        bitXor;
  logic [HALF_W-1:0] addrTerm, compTerm;

  always_comb begin
    bitXor = 3'd0;
    for (int j = 0; j < 8; j++)
      if (dataByte[j]) bitXor = bitXor ^ 3'(j);
    bytePar  = ^dataByte;
    addrTerm = {(bytePar ? posIdx : {IDX_W{1'b0}}), bitXor};
    compTerm = addrTerm ^ {HALF_W{bytePar}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrAcc <= '0;
      compAcc <= '0;
      posIdx  <= '0;
    end else if (strb.clearAcc) begin
      addrAcc <= '0;
      compAcc <= '0;
      posIdx  <= '0;
    end else if (strb.takeByte) begin
      addrAcc <= addrAcc ^ addrTerm;
      compAcc <= compAcc ^ compTerm;
      posIdx  <= posIdx + 1'b1;
    end
  end

  assign codeOut = ~{addrAcc, compAcc};

  // syndrome decode
  logic [CODE_W-1:0] syn;
  logic [IDX_W-1:0]  synIdx;
  logic [2:0]        synBit;
  logic              idxOk;
  eccStatus_t        nextStatus;

  assign syn    = codeOut ^ storedCode;
  assign synIdx = syn[CODE_W-1 -: IDX_W];
  assign synBit = syn[HALF_W+2:HALF_W];

  generate
    if (DATA_BYTES < (1 << IDX_W)) begin : g_rangeCheck
      assign idxOk = ({1'b0, synIdx} < (IDX_W+1)'(DATA_BYTES));
    end else begin : g_fullRange
      assign idxOk = 1'b1;
    end
  endgenerate

  always_comb begin
    if (syn == '0)
      nextStatus = ST_CLEAN;
    else if ((syn[CODE_W-1:HALF_W] ^ syn[HALF_W-1:0]) == {HALF_W{1'b1}})
      nextStatus = idxOk ? ST_FIXED : ST_BAD;
    else if ($countones(syn) == 1)
      nextStatus = ST_CODEHIT;
    else
      nextStatus = ST_BAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statusValid <= 1'b0;
      status      <= ST_CLEAN;
      fixByte     <= '0;
      fixMask     <= '0;
    end else begin
      statusValid <= strb.latchCheck;
      if (strb.latchCheck) begin
        status  <= nextStatus;
        fixByte <= (nextStatus == ST_FIXED) ? synIdx : '0;
        fixMask <= (nextStatus == ST_FIXED) ? (8'd1 << synBit) : 8'd0;
      end
    end
  end

  // R10: a compare request yields a result on the next cycle
  p_result_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strb.latchCheck |=> statusValid);

  // R5: a data fix flips exactly one bit
  p_fix_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (statusValid && status == ST_FIXED) |-> ($countones(fixMask) == 1));

  // R6: outcomes other than a data fix touch no data
  p_no_patch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (statusValid && status != ST_FIXED) |-> (fixMask == 8'd0));

  // R11: a clear leaves the erased-sector code
  p_clear_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clearAcc |=> (codeOut == {CODE_W{1'b1}}));
endmodule

// File: rtl/nand_ecc1b.sv
module nand_ecc1b
  import nand_ecc_pkg::*;
#(
  parameter int DATA_BYTES = 512,
  localparam int IDX_W  = $clog2(DATA_BYTES),
  localparam int CODE_W = 2 * (IDX_W + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              codeRead,
  input  logic              dataValid,
  input  logic [7:0]        dataByte,
  input  logic              checkValid,
  input  logic [CODE_W-1:0] storedCode,
  output logic [CODE_W-1:0] codeOut,
  output logic              done,
  output logic              statusValid,
  output logic [1:0]        status,
  output logic [IDX_W-1:0]  fixByte,
  output logic [7:0]        fixMask
);
  eccStrobe_t strb;
  eccStatus_t statusInt;

  eccCtrl #(.DATA_BYTES(DATA_BYTES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .codeRead  (codeRead),
    .dataValid (dataValid),
    .checkValid(checkValid),
    .strb      (strb),
    .done      (done)
  );

  eccDatapath #(.DATA_BYTES(DATA_BYTES)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .dataByte   (dataByte),
    .storedCode (storedCode),
    .codeOut    (codeOut),
    .statusValid(statusValid),
    .status     (statusInt),
    .fixByte    (fixByte),
    .fixMask    (fixMask)
  );

  assign status = statusInt;
endmodule

// File: tb/nand_ecc1b_bench.sv
module nand_ecc1b_bench;
  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, codeRead = 1'b0, dataValid = 1'b0, checkValid = 1'b0;
  logic [7:0]  dataByte = 8'd0;
  logic [23:0] storedCode = 24'd0;
  logic [23:0] codeOut;
  logic        done, statusValid;
  logic [1:0]  status;
  logic [8:0]  fixByte;
  logic [7:0]  fixMask;

  int checks = 0;
  int fails  = 0;
  logic [7:0]  sectorMem [0:511];
  logic [23:0] refVal;

  always #(CLK_NS/2) clk = ~clk;

  nand_ecc1b u_nand_ecc1b (
    .clk(clk), .rst_n(rst_n), .start(start), .codeRead(codeRead),
    .dataValid(dataValid), .dataByte(dataByte), .checkValid(checkValid),
    .storedCode(storedCode), .codeOut(codeOut), .done(done),
    .statusValid(statusValid), .status(status), .fixByte(fixByte),
    .fixMask(fixMask)
  );

  // {injected syndrome, status, fix byte, fix mask}
  localparam int NVEC = 9;
  localparam logic [42:0] VEC [0:NVEC-1] = '{
    {24'h000000, 2'd0, 9'd0,   8'h00},  // R4 clean
    {24'h000FFF, 2'd1, 9'd0,   8'h01},  // R5 byte 0 bit 0
    {24'hFFF000, 2'd1, 9'd511, 8'h80},  // R5 byte 511 bit 7
    {24'h96569A, 2'd1, 9'd300, 8'h20},  // R5 byte 300 bit 5
    {24'h000001, 2'd2, 9'd0,   8'h00},  // R6 code bit 0
    {24'h800000, 2'd2, 9'd0,   8'h00},  // R6 code bit 23
    {24'h001000, 2'd2, 9'd0,   8'h00},  // R6 code bit 12
    {24'h000003, 2'd3, 9'd0,   8'h00},  // R7 two bits
    {24'hFFFFFF, 2'd3, 9'd0,   8'h00}   // R7 all bits
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] refCode();
    logic [11:0] a, hi, lo;
    hi = '0;
    lo = '0;
    for (int i = 0; i < 512; i++)
      for (int j = 0; j < 8; j++)
        if (sectorMem[i][j]) begin
          a  = {i[8:0], j[2:0]};
          hi = hi ^ a;
          lo = lo ^ ~a;
        end
    return ~{hi, lo};
  endfunction

  task automatic feed(input int first, input int last);
    for (int k = first; k <= last; k++) begin
      @(negedge clk);
      dataValid = 1'b1;
      dataByte  = sectorMem[k];
    end
    @(negedge clk);
    dataValid = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulseRead();
    @(negedge clk); codeRead = 1'b1;
    @(negedge clk); codeRead = 1'b0;
  endtask

  task automatic compare(input logic [23:0] code);
    @(negedge clk);
    checkValid = 1'b1;
    storedCode = code;
    @(negedge clk);
    checkValid = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 codeOut", 32'(codeOut), 32'hFFFFFF);
    chk("R1 done", 32'(done), 0);
    chk("R1 statusValid", 32'(statusValid), 0);
    rst_n = 1'b1;

    // erased sector
    for (int i = 0; i < 512; i++) sectorMem[i] = 8'hFF;
    pulseStart();
    feed(0, 511);
    chk("R8 done erased", 32'(done), 1);
    chk("R2 erased code", 32'(codeOut), 32'hFFFFFF);
    compare(24'hFFFFFF);
    chk("R10 statusValid", 32'(statusValid), 1);
    chk("R4 erased clean", 32'(status), 0);
    @(negedge clk);
    chk("R10 statusValid drops", 32'(statusValid), 0);

    // code read clears and disarms
    for (int i = 0; i < 512; i++) sectorMem[i] = 8'(i * 37 + 11) ^ 8'(i >> 3);
    pulseRead();
    chk("R9 code after read", 32'(codeOut), 32'hFFFFFF);
    chk("R9 done after read", 32'(done), 0);
    feed(0, 15);
    chk("R9 bytes ignored", 32'(codeOut), 32'hFFFFFF);

    // patterned sector
    pulseStart();
    feed(0, 510);
    chk("R8 done before last", 32'(done), 0);
    feed(511, 511);
    chk("R8 done after last", 32'(done), 1);
    refVal = refCode();
    chk("R3 pattern code", 32'(codeOut), 32'(refVal));
    feed(0, 7);
    chk("R8 extra bytes ignored", 32'(codeOut), 32'(refVal));

    for (int v = 0; v < NVEC; v++) begin
      compare(refVal ^ VEC[v][42:19]);
      chk("R10 vec valid", 32'(statusValid), 1);
      chk("R4-R7 vec status", 32'(status), 32'(VEC[v][18:17]));
      chk("R5 vec fixByte", 32'(fixByte), 32'(VEC[v][16:8]));
      chk("R5/R6/R7 vec fixMask", 32'(fixMask), 32'(VEC[v][7:0]));
    end

    // start clears, then restarts at index 0
    pulseStart();
    chk("R11 cleared by start", 32'(codeOut), 32'hFFFFFF);
    chk("R11 done cleared", 32'(done), 0);
    for (int i = 0; i < 512; i++) sectorMem[i] = 8'h00;
    sectorMem[0] = 8'h80;
    feed(0, 0);
    chk("R11 single byte code", 32'(codeOut), 32'(refCode()));
    chk("R3 single byte literal", 32'(codeOut), 32'hFF8007);

    summary();
    $finish;
  end
endmodule